// File: doc/BRIEF.md
# Four-Channel Prioritized Queue Arbiter

This block decides, cycle by cycle, which of four queue channels may move one word between a shared buffer RAM and a peripheral function. Each channel carries a 4-bit function code that selects its peripheral and its direction. Even codes receive into the RAM, so the channel is a producer. Odd codes transmit out of the RAM, so the channel is a consumer. The codes are: USB 0/1, ATA 2/3, CompactFlash 4/5, Memory Stick 6/7, SD 8/9, SmartMedia 10/11. A channel competes when it is enabled, its code is valid and the addressed peripheral reports ready. The lowest-numbered competing channel wins. Channel index 0 is the top priority and index 3 the lowest.

Channels 0 and 1 can be joined into a ping-pong pair, and channels 2 and 3 into another. One member of a pair must produce and the other must consume, which gives a pass-through pipe from one peripheral to another with no processor in the loop. A typical set-up puts the USB side on the even (higher-priority) member. For a storage write the codes are 0 and 3. For a storage read they are 1 and 2. Each pair owns two buffer halves and tracks a full flag for each half. With the default 192 sixteen-bit words per half, the four halves fill a 0x600-byte window. A channel that is not paired cycles through its own region of one half's size.

The grant, the granted code, the RAM word address and the direction are combinational outputs of the current state. Channel counters and half flags advance at the clock edge that closes a granted cycle.

Top module: `qarb_top`

## Requirements
- R1: A channel is eligible only when its enable bit is high, its code is below 12 and `perReady[code]` is high. A disabled or idle channel keeps its word count and half pointer.
- R2: At most one grant bit is high. It goes to the lowest-indexed eligible channel.
- R3: A channel whose code is 12 to 15 is never granted.
- R4: A grant covers exactly one word. Arbitration is repeated every cycle, and each grant advances the granted channel's word count by one, wrapping from HALF_WORDS-1 to 0.
- R5: `grantCode` equals the granted channel's code. `grantWrite` is 1 for an even code (RAM is written) and 0 for an odd code. Both are 0 when nothing is granted.
- R6: For an unpaired channel c, `grantAddr` = c*HALF_WORDS + count.
- R7: For a paired channel in pair p (p = c/2), `grantAddr` = (2p + half)*HALF_WORDS + count. When a producer finishes a half, that half's full flag is set and its half pointer toggles. When a consumer finishes a half, the flag is cleared and its pointer toggles.
- R8: A paired producer is granted only if the half it points at is not full. A paired consumer is granted only if the half it points at is full.
- R9: If both members of a pair have the same direction, neither member is granted.
- R10: After reset all counts, half pointers and the `halfFull` flags are zero. `halfFull` bit 2p+h belongs to half h of pair p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 4 | Per-channel enable, bit c for channel c |
| reqCode | input | 16 | Function codes, channel c in bits [4c+3:4c] |
| pairEn | input | 2 | Bit p joins channels 2p and 2p+1 |
| perReady | input | 16 | Ready per function code |
| grant | output | 4 | One-hot grant for this cycle |
| grantCode | output | 4 | Code of the granted channel |
| grantWrite | output | 1 | 1 when the granted word is written into RAM |
| grantAddr | output | ADDR_W | RAM word address of the granted transfer |
| halfFull | output | 4 | Full flag per buffer half |

## Verification
The grant, code, direction and address respond in the same cycle as the inputs and the registered state. The bench changes the inputs just after a rising edge and compares them at the following falling edge. Counters and full flags change only at the rising edge that ends a granted cycle. The bench's reference model therefore updates its own state after each falling-edge comparison, and the `halfFull` value it expects in a cycle reflects every grant from earlier cycles but not the grant of the current cycle.

// File: rtl/qarb_pkg.sv
package qarb_pkg;
  localparam int NUM_CH = 4;
  localparam int NUM_PAIRS = NUM_CH / 2;
  localparam int CODE_W = 4;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int NUM_VALID_CODES = 12;

  // strobes handed from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] xfer;    // one-hot grant for this cycle
    logic [NUM_CH-1:0] prod;    // channel writes into RAM
    logic [NUM_CH-1:0] paired;  // channel is a member of a ping-pong pair
  } strobe_t;
endpackage

// File: rtl/qarb_ctrl.sv
module qarb_ctrl
  import qarb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chanEn,
  input  logic [NUM_CH*CODE_W-1:0] reqCode,
  input  logic [NUM_PAIRS-1:0]     pairEn,
  input  logic [NUM_CODES-1:0]     perReady,
  input  logic [NUM_CH-1:0]        chanHalf,
  input  logic [NUM_CH-1:0]        halfFull,
  output strobe_t                  stb,
  output logic [CODE_W-1:0]        grantCode
);
  logic [CODE_W-1:0] codeOf [NUM_CH];
  logic [NUM_CH-1:0] isProd, isPaired, codeOk, pairOk, bufOk, elig;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      codeOf[c]   = reqCode[c*CODE_W +: CODE_W];
      isProd[c]   = ~codeOf[c][0];
      isPaired[c] = pairEn[c/2];
      codeOk[c]   = (int'(codeOf[c]) < NUM_VALID_CODES);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      pairOk[c] = ~isPaired[c] | (isProd[c] ^ isProd[c ^ 1]);
      if (!isPaired[c])   bufOk[c] = 1'b1;
      else if (isProd[c]) bufOk[c] = ~halfFull[(c & 2) + int'(chanHalf[c])];
      else                bufOk[c] =  halfFull[(c & 2) + int'(chanHalf[c])];
      elig[c] = chanEn[c] & codeOk[c] & perReady[codeOf[c]] & pairOk[c] & bufOk[c];
    end
  end

  logic [NUM_CH-1:0] winVec;
  always_comb begin
    winVec = '0;
    grantCode = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (elig[c]) begin
        winVec = '0;
        winVec[c] = 1'b1;
        grantCode = codeOf[c];
      end
    end
  end

  assign stb.xfer   = winVec;
  assign stb.prod   = isProd;
  assign stb.paired = isPaired;

  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.xfer)); // R2

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_CODE_VALID: assert property (@(posedge clk) disable iff (!rstN)
      stb.xfer[g] |-> (reqCode[g*CODE_W +: CODE_W] < CODE_W'(NUM_VALID_CODES))); // R3
    AST_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
      stb.xfer[g] |-> chanEn[g]); // R1
  end
endmodule

// File: rtl/qarb_dpath.sv
module qarb_dpath
  import qarb_pkg::*;
#(
  parameter int HALF_WORDS = 192,
  parameter int ADDR_W = $clog2(NUM_CH * HALF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic [NUM_CH-1:0] chanHalf,
  output logic [NUM_CH-1:0] halfFull,
  output logic [ADDR_W-1:0] grantAddr,
  output logic              grantWrite
);
  localparam int CNT_W = (HALF_WORDS > 1) ? $clog2(HALF_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_WORDS - 1);
  localparam logic [ADDR_W-1:0] HALF_A = ADDR_W'(HALF_WORDS);

  logic [CNT_W-1:0] wordCnt [NUM_CH];
  logic [NUM_CH-1:0] halfPtr;
  logic [NUM_CH-1:0] fullFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) wordCnt[c] <= '0;
      halfPtr  <= '0;
      fullFlag <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (stb.xfer[c]) begin
          if (wordCnt[c] == LAST) begin
            wordCnt[c] <= '0;
            if (stb.paired[c]) begin
              halfPtr[c] <= ~halfPtr[c];
              fullFlag[(c & 2) + int'(halfPtr[c])] <= stb.prod[c];
            end
          end else begin
            wordCnt[c] <= wordCnt[c] + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    grantAddr = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (stb.xfer[c]) begin
        if (stb.paired[c])
          grantAddr = (ADDR_W'(c & 2) + ADDR_W'(halfPtr[c])) * HALF_A + ADDR_W'(wordCnt[c]);
        else
          grantAddr = ADDR_W'(c) * HALF_A + ADDR_W'(wordCnt[c]);
      end
    end
  end

  assign grantWrite = |(stb.xfer & stb.prod);
  assign chanHalf   = halfPtr;
  assign halfFull   = fullFlag;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      (stb.xfer[g] && stb.paired[g] && stb.prod[g]) |-> !fullFlag[(g & 2) + int'(halfPtr[g])]); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      (stb.xfer[g] && stb.paired[g] && !stb.prod[g]) |-> fullFlag[(g & 2) + int'(halfPtr[g])]); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !stb.xfer[g] |=> $stable(wordCnt[g])); // R4
    AST_HALF_SWAP: assert property (@(posedge clk) disable iff (!rstN)
      (stb.xfer[g] && stb.paired[g] && wordCnt[g] == LAST) |=> (halfPtr[g] != $past(halfPtr[g]))); // R7
  end
endmodule

// File: rtl/qarb_top.sv
module qarb_top
  import qarb_pkg::*;
#(
  parameter int HALF_WORDS = 192,
  parameter int ADDR_W = $clog2(4 * HALF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        chanEn,
  input  logic [15:0]       reqCode,
  input  logic [1:0]        pairEn,
  input  logic [15:0]       perReady,
  output logic [3:0]        grant,
  output logic [3:0]        grantCode,
  output logic              grantWrite,
  output logic [ADDR_W-1:0] grantAddr,
  output logic [3:0]        halfFull
);
  strobe_t stb;
  logic [NUM_CH-1:0] chanHalf;

  qarb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .reqCode(reqCode), .pairEn(pairEn),
    .perReady(perReady), .chanHalf(chanHalf), .halfFull(halfFull),
    .stb(stb), .grantCode(grantCode)
  );

  qarb_dpath #(.HALF_WORDS(HALF_WORDS), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .chanHalf(chanHalf), .halfFull(halfFull),
    .grantAddr(grantAddr), .grantWrite(grantWrite)
  );

  assign grant = stb.xfer;
endmodule

// File: tb/sim_qarb_top.sv
`timescale 1ns/1ps
module sim_qarb_top;
  localparam int HW = 4;
  localparam int AW = $clog2(4 * HW);

  logic clk = 0, rstN = 0;
  logic [3:0] chanEn = 0;
  logic [15:0] reqCode = 0, perReady = 0;
  logic [1:0] pairEn = 0;
  logic [3:0] grant, grantCode, halfFull;
  logic grantWrite;
  logic [AW-1:0] grantAddr;

  qarb_top #(.HALF_WORDS(HW)) u0 (.*);

  always #2 clk = ~clk;

  int nChk = 0, nBad = 0;
  int mCnt [4];
  int mHalf [4];
  int mFull [4];
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int codeOf(int c);
    return int'(reqCode[c*4 +: 4]);
  endfunction

  // expected winner from requirements R1,R2,R3,R8,R9
  function automatic int expWin();
    for (int c = 0; c < 4; c++) begin
      int k = codeOf(c);
      bit prod = (k % 2) == 0;
      bit pr = pairEn[c/2];
      bit ok = chanEn[c] && k < 12 && perReady[k];
      if (pr) begin
        bit pprod = (codeOf(c ^ 1) % 2) == 0;
        int fi = (c & 2) + mHalf[c];
        if (prod == pprod) ok = 0;
        if (prod && mFull[fi] != 0) ok = 0;
        if (!prod && mFull[fi] == 0) ok = 0;
      end
      if (ok) return c;
    end
    return -1;
  endfunction

  task automatic step(string tag);
    int w, hf;
    @(negedge clk);
    w = expWin();
    hf = mFull[0] + 2*mFull[1] + 4*mFull[2] + 8*mFull[3];
    chk({tag, " R10 halfFull"}, int'(halfFull), hf);
    if (w < 0) begin
      chk({tag, " R2 grant none"}, int'(grant), 0);
      chk({tag, " R5 write idle"}, int'(grantWrite), 0);
    end else begin
      int k = codeOf(w);
      int ea = pairEn[w/2] ? ((w & 2) + mHalf[w]) * HW + mCnt[w] : w * HW + mCnt[w];
      chk({tag, " R2 grant"}, int'(grant), 1 << w);
      chk({tag, " R5 code"}, int'(grantCode), k);
      chk({tag, " R5 write"}, int'(grantWrite), (k % 2) == 0);
      chk({tag, pairEn[w/2] ? " R7 addr" : " R6 addr"}, int'(grantAddr), ea);
      // R4 model update at the closing edge
      if (mCnt[w] == HW - 1) begin
        mCnt[w] = 0;
        if (pairEn[w/2]) begin
          mFull[(w & 2) + mHalf[w]] = (k % 2) == 0;
          mHalf[w] ^= 1;
        end
      end else mCnt[w]++;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin mCnt[c] = 0; mHalf[c] = 0; mFull[c] = 0; end
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state, nothing enabled
    chk("R10 reset grant", int'(grant), 0);
    chk("R10 reset halfFull", int'(halfFull), 0);
    rstN = 1;

    // R3: invalid codes with everything ready
    chanEn = 4'hF; perReady = 16'hFFFF; reqCode = 16'hFEDC; pairEn = 0;
    step("R3 invalid");
    step("R3 invalid");

    // R6 and R4: unpaired channel 2 alone, wrap across a region
    reqCode = 16'hF5FF; chanEn = 4'b0100;
    for (int i = 0; i < HW + 2; i++) step("R6 solo");
    // R1: disabled channel 2, then re-enabled keeps its count
    chanEn = 4'b0000; step("R1 disabled");
    chanEn = 4'b0100; step("R1 resume");

    // R9: both members of pair 0 producers
    pairEn = 2'b01; reqCode = 16'hFF20; chanEn = 4'b0011;
    step("R9 same dir"); step("R9 same dir");

    // R7/R8: storage-write pipe on pair 0, consumer blocked until a half fills
    reqCode = 16'hFF30; chanEn = 4'b0011;
    perReady = 16'h0008; step("R8 consumer empty");
    perReady = 16'hFFFF;
    for (int i = 0; i < 4 * HW + 4; i++) step("R8 pipe");
    // producer stalled, consumer drains
    perReady = 16'h0008;
    for (int i = 0; i < 3 * HW; i++) step("R7 drain");

    // storage-read pipe on pair 1
    pairEn = 2'b10; reqCode = 16'h21FF; chanEn = 4'b1100; perReady = 16'hFFFF;
    for (int i = 0; i < 4 * HW; i++) step("R7 read pipe");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        pairEn = 2'($urandom);
        if ($urandom % 2) reqCode = {4'd2, 4'd1, 4'd3, 4'd0};
        else reqCode = 16'($urandom);
      end
      chanEn = 4'($urandom) | 4'($urandom);
      perReady = 16'($urandom) | 16'($urandom);
      step("R1 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule